// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes two-channel digital audio from a serial data line that comes with a bit clock and a word clock. It turns each received word into a parallel 24-bit sample. Each sample leaves the block with a one-cycle valid strobe and a channel indicator. The block understands three framings:

- a left-justified word sent most-significant bit first;
- a right-justified word sent least-significant bit first;
- a 32-slot subframe that carries a sync preamble, the sample and four flag bits.

For the subframe framing, the block also recovers the flag bits and checks the parity.

The bit clock, word clock and data are sampled in the system clock domain, which must run at least twice as fast as the bit clock. The framing normally follows two mode pins. A host can write one configuration byte to select a register field as the format source instead. A new format is applied only at a word boundary, so the word in flight keeps the framing it started with.

Top module: `serial_audio_rx`

## Requirements
- R1: After reset the outputs are zero: `smp_valid`, `smp_ch`, `smp_data`, the flag outputs, `par_err`, `fmt_active` and `fmt_rsvd`. The configuration byte also resets to zero, so the pins choose the format.
- R2: Format code 0 is left-justified, MSB first. Bit 23 is the bit sampled on the first bit-clock rise that sees the new word-clock level. A sample is emitted after the 24th bit. Any further bits in that word are ignored.
- R3: Format code 1 is right-justified, LSB first. At a word-clock change, the last 24 bits of the word just ended are emitted, with the last bit as bit 23. A word shorter than 24 bits produces no sample.
- R4: Format code 2 is a 32-slot subframe whose slot 0 is the bit that starts the word. Slots 0-3 are ignored, slots 4-27 carry the sample LSB first, and slots 28, 29, 30 and 31 are driven on `aes_v`, `aes_u`, `aes_c` and `aes_p`. The sample is emitted after slot 31.
- R5: Parity is even over slots 4-31. `par_err[0]` (channel 1) or `par_err[1]` (channel 2) is updated with each subframe sample of that channel. It is 1 on a mismatch and holds until the next sample of that channel.
- R6: `smp_ch` is 0 for a word sent while the word clock is low (channel 1) and 1 for a word sent while it is high (channel 2).
- R7: A pulse on `cfg_we` stores `cfg_wdata[7]` as the source select and `cfg_wdata[1:0]` as the format field. With the select at 0 the format comes from `mode_pin`; with the select at 1 it comes from the field.
- R8: A requested format reaches `fmt_active` only at a word-clock change. A word that has started is finished in its old format.
- R9: Code 3 is reserved. It runs as code 0, `fmt_active` never shows 3, and it sets `fmt_rsvd`, which stays set until reset.
- R10: `smp_valid` is high for exactly one clock cycle per sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Serial bit clock, data taken on its rising edge |
| wclk | input | 1 | Word clock, low for channel 1 and high for channel 2 |
| sdata | input | 1 | Serial audio data |
| mode_pin | input | 2 | Format code from external pins |
| cfg_we | input | 1 | Host write strobe for the configuration byte |
| cfg_wdata | input | 8 | Host write data: bit 7 source select, bits 1:0 format |
| smp_valid | output | 1 | One-cycle strobe for a completed sample |
| smp_ch | output | 1 | Channel of the sample, 0 = channel 1 |
| smp_data | output | 24 | Received sample |
| aes_v | output | 1 | Validity flag from slot 28 |
| aes_u | output | 1 | User bit from slot 29 |
| aes_c | output | 1 | Channel status bit from slot 30 |
| aes_p | output | 1 | Parity bit from slot 31 |
| par_err | output | 2 | Per-channel parity error, bit 0 = channel 1 |
| fmt_active | output | 2 | Format currently applied |
| fmt_rsvd | output | 1 | Sticky flag for a reserved format request |

## Verification
Left-justified words end in trailing ones. A capture that ran past bit 24 would take those ones in, so the check separates correct MSB-first capture from over-capture.

Right-justified words are padded with leading ones and are followed by short words. This separates a correct last-24-bits capture from a first-24-bits capture, and shows that short words produce nothing.

Subframes are sent with good and bad parity on each channel, which tells the two per-channel parity flags apart. Further runs change the mode pins in the middle of a word, force the register override against conflicting pins, and request the reserved code, which shows whether the format switch waits for the word boundary.

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int SW = 24,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bclk,
  input  logic          wclk,
  input  logic          sdata,
  input  logic [1:0]    mode_pin,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  output logic          smp_valid,
  output logic          smp_ch,
  output logic [SW-1:0] smp_data,
  output logic          aes_v,
  output logic          aes_u,
  output logic          aes_c,
  output logic          aes_p,
  output logic [1:0]    par_err,
  output logic [1:0]    fmt_active,
  output logic          fmt_rsvd
);
  localparam logic [CW-1:0] I_D0  = CW'(4);
  localparam logic [CW-1:0] I_DN  = CW'(4 + SW - 1);
  localparam logic [CW-1:0] I_V   = CW'(4 + SW);
  localparam logic [CW-1:0] I_U   = CW'(5 + SW);
  localparam logic [CW-1:0] I_C   = CW'(6 + SW);
  localparam logic [CW-1:0] I_P   = CW'(7 + SW);
  localparam logic [CW-1:0] I_LJ  = CW'(SW - 1);
  localparam logic [CW-1:0] N_RJ  = CW'(SW);
  localparam logic [CW-1:0] CMAX  = '1;
  localparam logic [1:0]    F_LJ  = 2'd0;
  localparam logic [1:0]    F_RJ  = 2'd1;
  localparam logic [1:0]    F_AES = 2'd2;

  logic          bclk_q, primed, seen, wc_prev;
  logic [CW-1:0] cnt;
  logic [SW-1:0] sr;
  logic          sel_q;
  logic [1:0]    fld_q;
  logic          par_acc, v_q, u_q, c_q;
  logic          cfg_unused;

  assign cfg_unused = ^cfg_wdata[6:2];

  wire           rise     = bclk & ~bclk_q;
  wire           wc_edge  = rise & primed & (wclk != wc_prev);
  wire [1:0]     fmt_req  = sel_q ? fld_q : mode_pin;
  wire [1:0]     fmt_new  = (fmt_req == 2'd3) ? F_LJ : fmt_req;
  wire [1:0]     fmt_now  = wc_edge ? fmt_new : fmt_active;
  wire [CW-1:0]  idx      = wc_edge ? '0 : cnt;
  wire           is_aes   = fmt_now == F_AES;
  wire           aes_data = is_aes & (idx >= I_D0) & (idx <= I_DN);
  wire           aes_par  = is_aes & (idx >= I_D0) & (idx <= I_C);
  wire           rj_done  = wc_edge & seen & (fmt_active == F_RJ) & (cnt >= N_RJ);
  wire           lj_done  = rise & (fmt_now == F_LJ) & (idx == I_LJ);
  wire           aes_done = rise & is_aes & (idx == I_P);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q     <= 1'b0;
      primed     <= 1'b0;
      seen       <= 1'b0;
      wc_prev    <= 1'b0;
      cnt        <= '0;
      sr         <= '0;
      sel_q      <= 1'b0;
      fld_q      <= 2'd0;
      par_acc    <= 1'b0;
      v_q        <= 1'b0;
      u_q        <= 1'b0;
      c_q        <= 1'b0;
      smp_valid  <= 1'b0;
      smp_ch     <= 1'b0;
      smp_data   <= '0;
      aes_v      <= 1'b0;
      aes_u      <= 1'b0;
      aes_c      <= 1'b0;
      aes_p      <= 1'b0;
      par_err    <= 2'b00;
      fmt_active <= F_LJ;
      fmt_rsvd   <= 1'b0;
    end else begin
      bclk_q    <= bclk;
      smp_valid <= 1'b0;
      if (cfg_we) begin
        sel_q <= cfg_wdata[7];
        fld_q <= cfg_wdata[1:0];
      end
      if (rise) begin
        primed  <= 1'b1;
        wc_prev <= wclk;
        if (wc_edge) begin
          cnt        <= CW'(1);
          seen       <= 1'b1;
          par_acc    <= 1'b0;
          fmt_active <= fmt_new;
          if (fmt_req == 2'd3) fmt_rsvd <= 1'b1;
        end else if (cnt != CMAX) begin
          cnt <= cnt + CW'(1);
        end

        if (fmt_now == F_LJ)
          sr <= {sr[SW-2:0], sdata};
        else if (fmt_now == F_RJ || aes_data)
          sr <= {sdata, sr[SW-1:1]};

        if (aes_par) par_acc <= par_acc ^ sdata;
        if (is_aes && idx == I_V) v_q <= sdata;
        if (is_aes && idx == I_U) u_q <= sdata;
        if (is_aes && idx == I_C) c_q <= sdata;

        if (rj_done) begin
          smp_valid <= 1'b1;
          smp_ch    <= wc_prev;
          smp_data  <= sr;
          {aes_v, aes_u, aes_c, aes_p} <= 4'b0000;
        end
        if (lj_done) begin
          smp_valid <= 1'b1;
          smp_ch    <= wclk;
          smp_data  <= {sr[SW-2:0], sdata};
          {aes_v, aes_u, aes_c, aes_p} <= 4'b0000;
        end
        if (aes_done) begin
          smp_valid <= 1'b1;
          smp_ch    <= wclk;
          smp_data  <= sr;
          aes_v     <= v_q;
          aes_u     <= u_q;
          aes_c     <= c_q;
          aes_p     <= sdata;
          if (wclk) par_err[1] <= par_acc ^ sdata;
          else      par_err[0] <= par_acc ^ sdata;
        end
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rise,
  input logic       wc_edge,
  input logic       smp_valid,
  input logic [1:0] fmt_active,
  input logic       fmt_rsvd
);
  assert_strobe_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);

  assert_strobe_on_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> $past(rise));

  assert_fmt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wc_edge |=> $stable(fmt_active));

  assert_no_code3_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_active != 2'd3);

  assert_rsvd_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_rsvd |=> fmt_rsvd);
endmodule

bind serial_audio_rx serial_audio_rx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rise       (rise),
  .wc_edge    (wc_edge),
  .smp_valid  (smp_valid),
  .fmt_active (fmt_active),
  .fmt_rsvd   (fmt_rsvd)
);

// File: tb/serial_audio_rx_test.sv
`timescale 1ns/1ps
module serial_audio_rx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, wclk = 1'b1, sdata = 1'b0;
  logic [1:0]  mode_pin = 2'd0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic        smp_valid, smp_ch, aes_v, aes_u, aes_c, aes_p, fmt_rsvd;
  logic [23:0] smp_data;
  logic [1:0]  par_err, fmt_active;

  int n_chk = 0, n_fail = 0, cap_n = 0, dbl = 0;
  bit done = 0;
  logic [23:0] cap_d [32];
  logic        cap_ch [32];
  logic [3:0]  cap_x [32];
  logic [1:0]  cap_pe [32];
  logic        last_v = 1'b0;

  always #4 clk = ~clk;

  serial_audio_rx uut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .wclk(wclk), .sdata(sdata),
    .mode_pin(mode_pin), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .smp_valid(smp_valid), .smp_ch(smp_ch), .smp_data(smp_data),
    .aes_v(aes_v), .aes_u(aes_u), .aes_c(aes_c), .aes_p(aes_p),
    .par_err(par_err), .fmt_active(fmt_active), .fmt_rsvd(fmt_rsvd)
  );

  always @(negedge clk) begin
    if (smp_valid && last_v) dbl++;
    last_v = smp_valid;
    if (smp_valid && cap_n < 32) begin
      cap_d[cap_n]  = smp_data;
      cap_ch[cap_n] = smp_ch;
      cap_x[cap_n]  = {aes_v, aes_u, aes_c, aes_p};
      cap_pe[cap_n] = par_err;
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_smp(input int i, input logic ch, input logic [23:0] d, input string req);
    chk(cap_d[i] == d, req, {8'h0, cap_d[i]}, {8'h0, d});
    chk(cap_ch[i] == ch, {req, "/R6"}, 32'(cap_ch[i]), 32'(ch));
  endtask

  task automatic send_bit(input logic b, input logic w);
    @(negedge clk);
    sdata = b; wclk = w;
    repeat (3) @(negedge clk);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
    bclk = 1'b0;
  endtask

  task automatic send_pad(input logic w, input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1, w);
  endtask

  task automatic send_lj(input logic w, input logic [23:0] d);
    for (int i = 0; i < 32; i++) send_bit(i < 24 ? d[23-i] : 1'b1, w);
  endtask

  task automatic send_rj(input logic w, input logic [23:0] d);
    for (int i = 0; i < 32; i++) send_bit(i < 8 ? 1'b1 : d[i-8], w);
  endtask

  task automatic send_aes(input logic w, input logic [23:0] d, input logic v, input logic u,
                          input logic c, input logic bad);
    logic p;
    p = (^d) ^ v ^ u ^ c ^ bad;
    send_bit(1'b1, w); send_bit(1'b1, w); send_bit(1'b0, w); send_bit(1'b0, w);
    for (int i = 0; i < 24; i++) send_bit(d[i], w);
    send_bit(v, w); send_bit(u, w); send_bit(c, w); send_bit(p, w);
  endtask

  task automatic host_write(input logic [7:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset;
    chk(smp_valid == 0, "R1 valid", 32'(smp_valid), 0);
    chk(smp_data == 0, "R1 data", 32'(smp_data), 0);
    chk(par_err == 0, "R1 par_err", 32'(par_err), 0);
    chk(fmt_active == 0, "R1 fmt", 32'(fmt_active), 0);
    chk(fmt_rsvd == 0, "R1 rsvd", 32'(fmt_rsvd), 0);
    chk({aes_v, aes_u, aes_c, aes_p} == 0, "R1 flags", 32'({aes_v, aes_u, aes_c, aes_p}), 0);
  endtask

  task automatic t_lj;
    mode_pin = 2'd0;
    send_pad(1'b1, 1);
    cap_n = 0;
    send_lj(1'b0, 24'hA5C3F1);
    send_lj(1'b1, 24'h1B2D4E);
    chk(cap_n == 2, "R2 count", 32'(cap_n), 2);
    expect_smp(0, 1'b0, 24'hA5C3F1, "R2 ch1");
    expect_smp(1, 1'b1, 24'h1B2D4E, "R2 ch2");
  endtask

  task automatic t_rj;
    mode_pin = 2'd1;
    cap_n = 0;
    send_rj(1'b0, 24'h3C5A71);
    send_rj(1'b1, 24'hE0918B);
    send_rj(1'b0, 24'h7F0102);
    send_pad(1'b1, 8);
    send_pad(1'b0, 8);
    send_pad(1'b1, 8);
    chk(cap_n == 3, "R3 count incl short words", 32'(cap_n), 3);
    expect_smp(0, 1'b0, 24'h3C5A71, "R3 w0");
    expect_smp(1, 1'b1, 24'hE0918B, "R3 w1");
    expect_smp(2, 1'b0, 24'h7F0102, "R3 w2");
  endtask

  task automatic t_aes;
    mode_pin = 2'd2;
    cap_n = 0;
    send_aes(1'b0, 24'h123456, 1'b1, 1'b0, 1'b1, 1'b0);
    send_aes(1'b1, 24'hFEDCBA, 1'b0, 1'b1, 1'b0, 1'b0);
    chk(cap_n == 2, "R4 count", 32'(cap_n), 2);
    expect_smp(0, 1'b0, 24'h123456, "R4 ch1");
    expect_smp(1, 1'b1, 24'hFEDCBA, "R4 ch2");
    chk(cap_x[0] == {3'b101, (^24'h123456) ^ 1'b0}, "R4 flags ch1", 32'(cap_x[0]),
        32'({3'b101, (^24'h123456) ^ 1'b0}));
    chk(cap_x[1] == {3'b010, (^24'hFEDCBA) ^ 1'b1}, "R4 flags ch2", 32'(cap_x[1]),
        32'({3'b010, (^24'hFEDCBA) ^ 1'b1}));
    chk(cap_pe[1] == 2'b00, "R5 good parity", 32'(cap_pe[1]), 0);
  endtask

  task automatic t_parity;
    cap_n = 0;
    send_aes(1'b0, 24'h0F0F0F, 1'b0, 1'b0, 1'b0, 1'b0);
    send_aes(1'b1, 24'h800001, 1'b1, 1'b1, 1'b1, 1'b1);
    send_aes(1'b0, 24'h000007, 1'b0, 1'b0, 1'b0, 1'b1);
    send_aes(1'b1, 24'h55AA55, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(cap_n == 4, "R5 count", 32'(cap_n), 4);
    chk(cap_pe[0] == 2'b00, "R5 ch1 good", 32'(cap_pe[0]), 32'h0);
    chk(cap_pe[1] == 2'b10, "R5 ch2 bad", 32'(cap_pe[1]), 32'h2);
    chk(cap_pe[2] == 2'b11, "R5 ch1 bad", 32'(cap_pe[2]), 32'h3);
    chk(cap_pe[3] == 2'b01, "R5 ch2 good again", 32'(cap_pe[3]), 32'h1);
    chk(par_err == 2'b01, "R5 held", 32'(par_err), 32'h1);
  endtask

  task automatic t_override;
    host_write(8'h82);
    mode_pin = 2'd1;
    cap_n = 0;
    send_aes(1'b0, 24'h2468AC, 1'b0, 1'b0, 1'b1, 1'b0);
    send_aes(1'b1, 24'h13579B, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(cap_n == 2, "R7 count", 32'(cap_n), 2);
    expect_smp(0, 1'b0, 24'h2468AC, "R7 reg field wins");
    expect_smp(1, 1'b1, 24'h13579B, "R7 reg field wins");
    chk(fmt_active == 2'd2, "R7 fmt", 32'(fmt_active), 2);
    host_write(8'h00);
    mode_pin = 2'd0;
  endtask

  task automatic t_midword;
    logic [23:0] x;
    x = 24'hC0FFEE;
    cap_n = 0;
    for (int i = 0; i < 32; i++) begin
      send_bit(i < 24 ? x[23-i] : 1'b1, 1'b0);
      if (i == 10) begin
        mode_pin = 2'd2;
        chk(fmt_active == 2'd0, "R8 mid-word fmt", 32'(fmt_active), 0);
      end
    end
    chk(fmt_active == 2'd0, "R8 end-of-word fmt", 32'(fmt_active), 0);
    send_aes(1'b1, 24'h0A0B0C, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(cap_n == 2, "R8 count", 32'(cap_n), 2);
    expect_smp(0, 1'b0, 24'hC0FFEE, "R8 old format kept");
    expect_smp(1, 1'b1, 24'h0A0B0C, "R8 new format at edge");
    chk(fmt_active == 2'd2, "R8 switched", 32'(fmt_active), 2);
  endtask

  task automatic t_reserved;
    chk(fmt_rsvd == 1'b0, "R9 before", 32'(fmt_rsvd), 0);
    mode_pin = 2'd3;
    cap_n = 0;
    send_lj(1'b0, 24'h9ABCDE);
    send_lj(1'b1, 24'h000100);
    chk(cap_n == 2, "R9 count", 32'(cap_n), 2);
    expect_smp(0, 1'b0, 24'h9ABCDE, "R9 runs as code 0");
    expect_smp(1, 1'b1, 24'h000100, "R9 runs as code 0");
    chk(fmt_active == 2'd0, "R9 fmt", 32'(fmt_active), 0);
    chk(fmt_rsvd == 1'b1, "R9 flag", 32'(fmt_rsvd), 1);
    mode_pin = 2'd0;
    send_lj(1'b0, 24'h111111);
    chk(fmt_rsvd == 1'b1, "R9 sticky", 32'(fmt_rsvd), 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_lj();
    t_rj();
    t_aes();
    t_parity();
    t_override();
    t_midword();
    t_reserved();
    chk(dbl == 0, "R10 strobe width", 32'(dbl), 0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule